// File: doc/BRIEF.md
# Single-Channel Fly-By Block Transfer Engine

This block moves a block of words between one peripheral and main memory while the processor gets on with other work. Software programs it through a small register port. It sets the start memory address, the number of words, the direction and which device takes part, and then writes a go bit. The engine first waits for the device to report that its internal buffer holds valid data. It then requests the system bus and waits for a grant.

For each word, the engine places the memory address on the bus and raises a per-word request to the device. The device moves the word itself, using an ordinary memory cycle, so the data never passes through the engine. The device then acknowledges. Each acknowledge advances the address by one word and lowers the remaining count. The engine has two bus modes. In cycle-steal mode it gives the bus back after every word. In burst mode it keeps the bus until the block ends. When the count runs out, the engine raises an interrupt that stays up until software clears it.

The controller runs through six named states:
- IDLE: waiting for a go command.
- WAIT_READY: waiting for the device to report valid data.
- REQ_BUS: bus requested, waiting for the grant.
- XFER: address phase of one word.
- WAIT_ACK: waiting for the device's per-word acknowledge.
- DONE: one cycle that raises the interrupt.

The transitions are:
- IDLE to WAIT_READY on an accepted go with a nonzero count.
- IDLE to DONE on an accepted go with a zero count.
- WAIT_READY to REQ_BUS when the device is ready.
- REQ_BUS to XFER on grant.
- XFER to WAIT_ACK always.
- WAIT_ACK to DONE on the acknowledge of the last word.
- WAIT_ACK to XFER on any other acknowledge in burst mode.
- WAIT_ACK to WAIT_READY on any other acknowledge in cycle-steal mode.
- DONE to IDLE always.

Top module: `dmac_top`

## Requirements
- R1: After reset the engine is in IDLE. bus_req, dev_req and irq are low, and every register reads zero.
- R2: The register map is as follows, with cfg_addr selecting the register.
  - Register 0 holds the memory address.
  - Register 1 holds the remaining word count.
  - Register 2 is the control register. Bit 1 is the direction, bit 2 selects burst mode and bits 11:8 hold the device number. Bit 0 is the go bit, which reads back as 0.
  - Register 3 is the status register. Bit 0 is busy, bit 1 is done, bit 2 is error and bits 23:16 hold the remaining count. Writing 1 to status bit 1 clears done, and writing 1 to status bit 2 clears error.
- R3: After a go with a nonzero count, bus_req stays low for as long as dev_ready is low. The transfer starts once dev_ready is high.
- R4: dev_req is raised only while bus_req is held and after bus_gnt has been seen.
- R5: During a word, dev_req, mem_addr, dev_sel and xfer_dir hold steady until dev_ack. dev_ack is taken only in WAIT_ACK, and no new word begins before it. Exactly the programmed number of words is moved.
- R6: Each accepted acknowledge adds 4 to the address, wrapping at 16 bits, and subtracts one from the count.
- R7: In cycle-steal mode, bus_req drops after every word, and the next word waits for dev_ready again.
- R8: In burst mode, bus_req stays high from the first grant until the last acknowledge, and words follow back to back.
- R9: The cycle after DONE, irq and status done are set, busy is clear and the count reads zero. irq then holds until status bit 1 is written.
- R10: A go written while busy is ignored and sets the error bit. The error bit holds until status bit 2 is written.
- R11: Writes to registers 0, 1 and 2 while busy are ignored.
- R12: A go with a zero count passes through DONE and raises irq without asserting bus_req.
- R13: An accepted go clears a pending done flag and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected register (combinational) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| dev_ready | input | 1 | Device has valid data buffered |
| dev_req | output | 1 | Per-word transfer request to the device |
| dev_sel | output | 4 | Programmed device number |
| xfer_dir | output | 1 | Programmed direction |
| mem_addr | output | 16 | Memory address of the current word |
| dev_ack | input | 1 | Device per-word acknowledge |
| irq | output | 1 | Block-complete interrupt |

## Verification
The bound checker checks these rules on every cycle:
- bus ownership before any word strobe;
- a stable address while a word is outstanding;
- release of the bus after each cycle-steal word;
- an unbroken bus hold between burst words;
- an interrupt that rises only out of DONE and never falls without a clear.

Only the bench scenarios can show the rest: the exact word count and address sequence over a sweep of counts, modes, directions and a wrapping address; the ready gating; zero-count completion; and the handling of writes and go commands made while the engine is busy.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_READY,
        ST_REQ_BUS,
        ST_XFER,
        ST_WAIT_ACK,
        ST_DONE
    } dmac_state_e;

    localparam logic [1:0] REG_ADDR  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;

    localparam int CTRL_GO      = 0;
    localparam int CTRL_DIR     = 1;
    localparam int CTRL_BURST   = 2;
    localparam int CTRL_DEV_LSB = 8;

    localparam int STAT_BUSY    = 0;
    localparam int STAT_DONE    = 1;
    localparam int STAT_ERR     = 2;
    localparam int STAT_CNT_LSB = 16;

    localparam int REG_W = 32;

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 8,
    parameter int DEVW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             busy,
    input  logic             done_evt,
    input  logic [AW-1:0]    addr_q,
    input  logic [CW-1:0]    cnt_q,
    output logic             ld_addr,
    output logic             ld_cnt,
    output logic             start,
    output logic             dir_q,
    output logic             burst_q,
    output logic [DEVW-1:0]  dev_q,
    output logic             done_q,
    output logic             err_q,
    output logic [REG_W-1:0] cfg_rdata
);

    logic wr_ctrl;
    logic wr_stat;
    logic go_req;

    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
        wr_stat = cfg_we && (cfg_addr == REG_STAT);
        go_req  = wr_ctrl && cfg_wdata[CTRL_GO];
        ld_addr = cfg_we && (cfg_addr == REG_ADDR) && !busy;
        ld_cnt  = cfg_we && (cfg_addr == REG_COUNT) && !busy;
        start   = go_req && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            burst_q <= 1'b0;
            dev_q   <= '0;
        end else if (wr_ctrl && !busy) begin
            dir_q   <= cfg_wdata[CTRL_DIR];
            burst_q <= cfg_wdata[CTRL_BURST];
            dev_q   <= cfg_wdata[CTRL_DEV_LSB +: DEVW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (done_evt) begin
                done_q <= 1'b1;
            end else if (start || (wr_stat && cfg_wdata[STAT_DONE])) begin
                done_q <= 1'b0;
            end
            if (go_req && busy) begin
                err_q <= 1'b1;
            end else if (wr_stat && cfg_wdata[STAT_ERR]) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            REG_ADDR:  cfg_rdata[AW-1:0] = addr_q;
            REG_COUNT: cfg_rdata[CW-1:0] = cnt_q;
            REG_CTRL: begin
                cfg_rdata[CTRL_DIR]              = dir_q;
                cfg_rdata[CTRL_BURST]            = burst_q;
                cfg_rdata[CTRL_DEV_LSB +: DEVW]  = dev_q;
            end
            REG_STAT: begin
                cfg_rdata[STAT_BUSY]             = busy;
                cfg_rdata[STAT_DONE]             = done_q;
                cfg_rdata[STAT_ERR]              = err_q;
                cfg_rdata[STAT_CNT_LSB +: CW]    = cnt_q;
            end
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
    parameter int AW     = 16,
    parameter int CW     = 8,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_cnt,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic [CW-1:0] cnt_q,
    output logic          cnt_last,
    output logic          cnt_zero
);

    localparam logic [AW-1:0] ADDR_STEP = AW'(STRIDE);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_addr) begin
            addr_q <= wr_addr;
        end else if (step) begin
            addr_q <= addr_q + ADDR_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_cnt) begin
            cnt_q <= wr_cnt;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    always_comb begin
        cnt_last = (cnt_q == CNT_ONE);
        cnt_zero = (cnt_q == '0);
    end

endmodule

// File: rtl/dmac_fsm.sv
module dmac_fsm
    import dmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        cnt_zero,
    input  logic        cnt_last,
    input  logic        burst,
    input  logic        dev_ready,
    input  logic        bus_gnt,
    input  logic        dev_ack,
    output dmac_state_e state,
    output logic        step,
    output logic        done_evt,
    output logic        bus_req,
    output logic        dev_req
);

    dmac_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = cnt_zero ? ST_DONE : ST_WAIT_READY;
                end
            end
            ST_WAIT_READY: begin
                if (dev_ready) begin
                    state_nx = ST_REQ_BUS;
                end
            end
            ST_REQ_BUS: begin
                if (bus_gnt) begin
                    state_nx = ST_XFER;
                end
            end
            ST_XFER: state_nx = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (dev_ack) begin
                    if (cnt_last) begin
                        state_nx = ST_DONE;
                    end else if (burst) begin
                        state_nx = ST_XFER;
                    end else begin
                        state_nx = ST_WAIT_READY;
                    end
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = 1'b0;
        dev_req  = 1'b0;
        step     = 1'b0;
        done_evt = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT_READY: ;
            ST_REQ_BUS: bus_req = 1'b1;
            ST_XFER: begin
                bus_req = 1'b1;
                dev_req = 1'b1;
            end
            ST_WAIT_ACK: begin
                bus_req = 1'b1;
                dev_req = 1'b1;
                step    = dev_ack;
            end
            ST_DONE: done_evt = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int AW     = 16,
    parameter int CW     = 8,
    parameter int DEVW   = 4,
    parameter int STRIDE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             bus_req,
    input  logic             bus_gnt,
    input  logic             dev_ready,
    output logic             dev_req,
    output logic [DEVW-1:0]  dev_sel,
    output logic             xfer_dir,
    output logic [AW-1:0]    mem_addr,
    input  logic             dev_ack,
    output logic             irq
);

    dmac_state_e     fsm_state;
    logic            busy;
    logic            ld_addr;
    logic            ld_cnt;
    logic            start;
    logic            step;
    logic            done_evt;
    logic            dir_q;
    logic            burst_q;
    logic [DEVW-1:0] dev_q;
    logic            done_q;
    logic            err_q;
    logic [AW-1:0]   chan_addr;
    logic [CW-1:0]   chan_cnt;
    logic            cnt_last;
    logic            cnt_zero;

    assign busy = (fsm_state != ST_IDLE);

    dmac_regs #(.AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .done_evt  (done_evt),
        .addr_q    (chan_addr),
        .cnt_q     (chan_cnt),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .start     (start),
        .dir_q     (dir_q),
        .burst_q   (burst_q),
        .dev_q     (dev_q),
        .done_q    (done_q),
        .err_q     (err_q),
        .cfg_rdata (cfg_rdata)
    );

    dmac_chan #(.AW(AW), .CW(CW), .STRIDE(STRIDE)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (ld_addr),
        .ld_cnt   (ld_cnt),
        .wr_addr  (cfg_wdata[AW-1:0]),
        .wr_cnt   (cfg_wdata[CW-1:0]),
        .step     (step),
        .addr_q   (chan_addr),
        .cnt_q    (chan_cnt),
        .cnt_last (cnt_last),
        .cnt_zero (cnt_zero)
    );

    dmac_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .burst     (burst_q),
        .dev_ready (dev_ready),
        .bus_gnt   (bus_gnt),
        .dev_ack   (dev_ack),
        .state     (fsm_state),
        .step      (step),
        .done_evt  (done_evt),
        .bus_req   (bus_req),
        .dev_req   (dev_req)
    );

    assign dev_sel  = dev_q;
    assign xfer_dir = dir_q;
    assign mem_addr = chan_addr;
    assign irq      = done_q;

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             dev_req,
    input logic             dev_ack,
    input logic [AW-1:0]    mem_addr,
    input logic             irq,
    input dmac_state_e      state,
    input logic             burst,
    input logic [CW-1:0]    cnt
);

    logic irq_clear_wr;
    assign irq_clear_wr = cfg_we &&
        (((cfg_addr == REG_STAT) && cfg_wdata[STAT_DONE]) ||
         ((cfg_addr == REG_CTRL) && cfg_wdata[CTRL_GO]));

    // R4
    strobe_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req |-> bus_req);

    // R4
    strobe_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_req) |-> $past(bus_gnt));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> $stable(mem_addr));

    // R7
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_ACK && dev_ack && !burst) |=> !bus_req);

    // R8
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_ACK && dev_ack && burst && cnt != CW'(1)) |=> (bus_req && dev_req));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear_wr) |=> irq);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state == ST_DONE));

endmodule

bind dmac_top dmac_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .dev_req   (dev_req),
    .dev_ack   (dev_ack),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .state     (fsm_state),
    .burst     (burst_q),
    .cnt       (chan_cnt)
);

// File: tb/dmac_top_test.sv
`timescale 1ns/1ps
module dmac_top_test;

    localparam int AW     = 16;
    localparam int CW     = 8;
    localparam int DEVW   = 4;
    localparam int STRIDE = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             bus_req;
    logic             bus_gnt = 1'b0;
    logic             dev_ready = 1'b1;
    logic             dev_req;
    logic [DEVW-1:0]  dev_sel;
    logic             xfer_dir;
    logic [AW-1:0]    mem_addr;
    logic             dev_ack = 1'b0;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;

    // device/arbiter model state
    int          ack_delay = 2;
    int          ack_wait = 0;
    int          words = 0;
    int          addr_bad = 0;
    int          attr_bad = 0;
    int          gnt_bad = 0;
    int          req_falls = 0;
    int          ready_bad = 0;
    bit          expect_no_bus = 1'b0;
    bit          prev_req = 1'b0;
    logic [AW-1:0]   exp_addr = '0;
    logic [DEVW-1:0] exp_dev = '0;
    logic            exp_dir = 1'b0;

    always #4 clk = ~clk;

    dmac_top #(.AW(AW), .CW(CW), .DEVW(DEVW), .STRIDE(STRIDE)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .dev_ready(dev_ready), .dev_req(dev_req),
        .dev_sel(dev_sel), .xfer_dir(xfer_dir), .mem_addr(mem_addr),
        .dev_ack(dev_ack), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_finish();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Arbiter and fly-by device model: grant follows request one half-cycle
    // later, acknowledge comes ack_delay cycles into each word.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_gnt  = 1'b0;
                dev_ack  = 1'b0;
                ack_wait = 0;
                prev_req = 1'b0;
            end else begin
                if (dev_req && !bus_gnt) gnt_bad++;
                if (bus_req && expect_no_bus) ready_bad++;
                if (prev_req && !bus_req) req_falls++;
                prev_req = bus_req;
                if (dev_ack) begin
                    dev_ack  = 1'b0;
                    ack_wait = dev_req ? 1 : 0;
                end else if (dev_req) begin
                    ack_wait++;
                    if (ack_wait >= ack_delay) begin
                        dev_ack = 1'b1;
                        if (mem_addr !== exp_addr) addr_bad++;
                        if (dev_sel !== exp_dev || xfer_dir !== exp_dir) attr_bad++;
                        words++;
                        exp_addr = exp_addr + AW'(STRIDE);
                    end
                end else begin
                    ack_wait = 0;
                end
                bus_gnt = bus_req;
            end
        end
    end

    initial begin
        #(8 * 190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_finish();
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input bit go, input bit dir,
                                              input bit burst, input int dev);
        logic [31:0] w;
        w = '0;
        w[0] = go;
        w[1] = dir;
        w[2] = burst;
        w[11:8] = 4'(dev);
        return w;
    endfunction

    task automatic wait_irq(output int cycles);
        cycles = 0;
        while (irq !== 1'b1 && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic run_block(input logic [AW-1:0] start, input int cnt,
                             input bit burst, input int dev, input bit dir,
                             input int delay);
        logic [31:0] r;
        int          cyc;
        int          exp_falls;
        exp_addr  = start;
        exp_dev   = DEVW'(dev);
        exp_dir   = dir;
        words     = 0;
        addr_bad  = 0;
        attr_bad  = 0;
        gnt_bad   = 0;
        req_falls = 0;
        ack_delay = delay;
        wr(2'd0, 32'(start));
        wr(2'd1, 32'(cnt));
        wr(2'd2, ctrl_word(1'b1, dir, burst, dev));
        wait_irq(cyc);
        check("R9", "irq after block", 32'(irq), 32'd1);
        check("R5", "words moved", 32'(words), 32'(cnt));
        check("R6", "address sequence errors", 32'(addr_bad), 32'd0);
        check("R5", "device/direction errors", 32'(attr_bad), 32'd0);
        check("R4", "strobe without grant", 32'(gnt_bad), 32'd0);
        exp_falls = (cnt == 0) ? 0 : (burst ? 1 : cnt);
        if (burst) check("R8", "bus releases in burst", 32'(req_falls), 32'(exp_falls));
        else       check("R7", "bus releases in cycle-steal", 32'(req_falls), 32'(exp_falls));
        if (cnt == 0) check("R12", "zero count bus activity", 32'(req_falls + words), 32'd0);
        rd(2'd3, r);
        check("R9", "status after block", r, 32'h0000_0002);
        rd(2'd0, r);
        check("R6", "final address", r, 32'(AW'(start + AW'(cnt * STRIDE))));
        repeat (3) @(negedge clk);
        check("R9", "irq held", 32'(irq), 32'd1);
        wr(2'd3, 32'h2);
        check("R9", "irq after clear", 32'(irq), 32'd0);
    endtask

    initial begin
        logic [31:0] r;
        int          cyc;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "bus_req in reset", 32'(bus_req), 32'd0);
        check("R1", "irq in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "dev_req after reset", 32'(dev_req), 32'd0);
        for (int k = 0; k < 4; k++) begin
            rd(2'(k), r);
            check("R1", "register after reset", r, 32'd0);
        end

        // R2: register programming and readback while idle
        wr(2'd0, 32'h0000_1234);
        wr(2'd1, 32'h0000_0005);
        wr(2'd2, ctrl_word(1'b0, 1'b1, 1'b1, 9));
        rd(2'd0, r); check("R2", "address register", r, 32'h1234);
        rd(2'd1, r); check("R2", "count register", r, 32'h5);
        rd(2'd2, r); check("R2", "control register", r, 32'h0000_0906);
        rd(2'd3, r); check("R2", "status register idle", r, 32'h0005_0000);

        // Sweep over counts, both bus modes, both directions
        for (int b = 0; b < 2; b++) begin
            for (int n = 0; n <= 6; n++) begin
                run_block(AW'(16'h1000 + n * 16'h40), n, b[0], n + b, n[0], 2 + (n % 2));
            end
        end
        // R6: address wraps at 16 bits
        run_block(16'hFFF8, 4, 1'b1, 3, 1'b0, 2);
        // long cycle-steal block at full count
        run_block(16'h2000, 255, 1'b0, 15, 1'b1, 2);

        // R12: zero count, leave irq pending for the next step
        wr(2'd1, 32'd0);
        wr(2'd2, ctrl_word(1'b1, 1'b0, 1'b0, 1));
        repeat (2) @(negedge clk);
        check("R12", "zero count irq", 32'(irq), 32'd1);

        // R3: ready gating; R13: accepted go clears pending irq
        dev_ready = 1'b0;
        expect_no_bus = 1'b1;
        ready_bad = 0;
        words = 0;
        addr_bad = 0;
        attr_bad = 0;
        exp_addr = 16'h0300;
        exp_dev = 4'd6;
        exp_dir = 1'b0;
        ack_delay = 3;
        wr(2'd0, 32'h0300);
        wr(2'd1, 32'd3);
        wr(2'd2, ctrl_word(1'b1, 1'b0, 1'b0, 6));
        check("R13", "irq cleared by go", 32'(irq), 32'd0);
        repeat (12) @(negedge clk);
        check("R3", "bus requested while not ready", 32'(ready_bad), 32'd0);
        rd(2'd3, r);
        check("R3", "status while waiting", r, 32'h0003_0001);

        // R10: go while busy; R11: writes while busy
        wr(2'd2, ctrl_word(1'b1, 1'b1, 1'b1, 2));
        rd(2'd3, r);
        check("R10", "error after busy go", r, 32'h0003_0005);
        wr(2'd0, 32'h5555);
        rd(2'd0, r);
        check("R11", "address write while busy", r, 32'h0300);
        wr(2'd1, 32'd9);
        rd(2'd1, r);
        check("R11", "count write while busy", r, 32'd3);
        rd(2'd2, r);
        check("R11", "control write while busy", r, 32'h0000_0600);

        expect_no_bus = 1'b0;
        dev_ready = 1'b1;
        wait_irq(cyc);
        check("R3", "words after ready", 32'(words), 32'd3);
        check("R6", "address errors after ready", 32'(addr_bad), 32'd0);
        check("R11", "attributes unchanged", 32'(attr_bad), 32'd0);
        rd(2'd3, r);
        check("R10", "error held after block", r, 32'h0000_0006);
        wr(2'd3, 32'h4);
        rd(2'd3, r);
        check("R10", "error cleared", r, 32'h0000_0002);
        wr(2'd3, 32'h2);
        check("R9", "irq cleared", 32'(irq), 32'd0);

        summary_and_finish();
    end

endmodule